// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block multiplies two 16-bit two's-complement operands and folds the product into a 40-bit accumulator. It can either add the product to the accumulator or replace the accumulator with it. A host drives it through a byte-wide register write port. Writing the low byte of operand B launches an operation, which then runs through three one-clock stages: multiply, accumulate, and round. A new launch may be issued while the previous operation is in its accumulate stage, so the unit sustains one operation every two clocks.

Next to the accumulate path, the unit always presents a 16-bit rounded view of the accumulator, with optional saturation. It keeps three status flags. A clear request can be armed so that it takes effect at the next launch. A self-clearing arithmetic shift moves the accumulator by one bit in either direction.

Top module: `mac_pipe`

## Requirements
- R1: After reset, the accumulator, the flags, the rounded output and the configuration all read zero.
- R2: Write addresses select the registers as follows: 0 = A low byte, 1 = A high byte, 2 = B high byte, 3 = B low byte, 4 = configuration, 5 = flags, 6..10 = accumulator bytes 0 (least significant) to 4. A write to address 3 launches an operation.
- R3: When configuration bit 0 is 0, the signed product, sign-extended to 40 bits, is added to the accumulator. The accumulator takes the new value on the second rising edge after the launch edge and keeps its previous value on the first.
- R4: When configuration bit 0 is 1, the accumulator is overwritten with the sign-extended product. In this mode the hard-overflow flag keeps its value.
- R5: The rounded output is registered one edge after the accumulator. Its value is accumulator bits [31:16] plus bit 15, computed as a 17-bit sum of {bit31, bits[31:16]} and bit 15, keeping the low 16 bits.
- R6: When configuration bit 1 is set and either accumulator bits [39:31] are not all equal or the 17-bit rounding sum overflows, the rounded output clamps to 0x7FFF if bit 39 is 0 and to 0x8000 if bit 39 is 1.
- R7: Flag bit 0 (zero) is written at each accumulate stage and is 1 when the new accumulator value is zero. Flag bit 1 (soft overflow) becomes sticky-set when the new value's bits [39:31] are not all equal. Flag bit 2 (hard overflow) becomes sticky-set when the 40-bit signed add overflows.
- R8: If configuration bit 2 is set when an operation is launched, the accumulator and all flags are cleared on the next edge and bit 2 clears itself. The launched operation then completes against the cleared accumulator.
- R9: Writing configuration bit 3 as 1 shifts the accumulator by one bit on the next edge: left when bit 4 is 0, right with bit 39 copied into the vacated top bit when bit 4 is 1. Bit 3 then reads 0, and the flags do not change.
- R10: Two launches two clocks apart both complete, so the accumulator ends up holding the sum of both products.
- R11: A host write to an accumulator byte or to the flags wins over a pipeline update in the same cycle. The other accumulator bytes keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| acc_o | output | 40 | Accumulator |
| rnd_o | output | 16 | Rounded, optionally saturated, result |
| flags_o | output | 3 | Status flags {hard overflow, soft overflow, zero} |
| cfg_o | output | 5 | Configuration register |

## Verification
Random operand pairs are launched against random preloaded accumulators in both modes. This distinguishes sign-extension and add errors from mode-selection errors, and reaches soft overflow and saturation often. Directed cases use the operand extremes 0x8000 and 0x7FFF against an accumulator next to its positive limit, which separates hard overflow from soft overflow and shows that multiply-only mode leaves the hard-overflow flag alone. Launches two clocks apart expose lost or duplicated pipeline results. A host write landing in the accumulate cycle shows which side wins. Timed samples at the first, second and third clock after a launch pin down the latency of the accumulator and of the rounded output. Shifts in both directions on negative values show whether sign fill is correct.

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [ACCW-1:0] acc_o,
  output logic [15:0]     rnd_o,
  output logic [2:0]      flags_o,
  output logic [4:0]      cfg_o
);
  localparam int NB = ACCW / 8;
  localparam int XW = ACCW - 32;

  logic [15:0]        a_q, b_q, rnd_q;
  logic [4:0]         cfg_q;
  logic [2:0]         flg_q;
  logic [ACCW-1:0]    acc_q;
  logic               go_q, s1_v, s1_mode;
  logic signed [31:0] prod_q;

  wire launch  = wr_en && wr_addr == 4'd3;
  wire cfg_wr  = wr_en && wr_addr == 4'd4;
  wire flg_wr  = wr_en && wr_addr == 4'd5;
  wire acc_wr  = wr_en && wr_addr >= 4'd6 && wr_addr < 4'(6 + NB);
  wire clr_now = go_q && cfg_q[2];
  wire shf_now = cfg_q[3];

  wire signed [31:0] mul  = $signed(a_q) * $signed(b_q);
  wire [ACCW-1:0]    base = s1_mode ? '0 : acc_q;
  wire [ACCW-1:0]    pext = {{XW{prod_q[31]}}, prod_q};
  wire [ACCW-1:0]    sum  = base + pext;
  wire hov  = (base[ACCW-1] == pext[ACCW-1]) && (sum[ACCW-1] != base[ACCW-1]);
  wire sov  = !(&sum[ACCW-1:31] || ~|sum[ACCW-1:31]);

  wire        hi_ok = &acc_q[ACCW-1:31] || ~|acc_q[ACCW-1:31];
  wire [16:0] rsum  = {acc_q[31], acc_q[31:16]} + {16'd0, acc_q[15]};
  wire [15:0] rnd_nxt = (cfg_q[1] && (!hi_ok || rsum[16] != rsum[15]))
                      ? (acc_q[ACCW-1] ? 16'h8000 : 16'h7fff) : rsum[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; cfg_q <= '0; flg_q <= '0; acc_q <= '0;
      rnd_q <= '0; go_q <= 1'b0; s1_v <= 1'b0; s1_mode <= 1'b0; prod_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          4'd0: a_q[7:0]  <= wr_data;
          4'd1: a_q[15:8] <= wr_data;
          4'd2: b_q[15:8] <= wr_data;
          4'd3: b_q[7:0]  <= wr_data;
          default: ;
        endcase
      end
      go_q <= launch;
      s1_v <= go_q;
      if (go_q) begin
        prod_q  <= mul;
        s1_mode <= cfg_q[0];
      end

      if (cfg_wr) cfg_q <= wr_data[4:0];
      else begin
        if (clr_now) cfg_q[2] <= 1'b0;
        if (shf_now) cfg_q[3] <= 1'b0;
      end

      if (acc_wr) begin
        for (int i = 0; i < NB; i++)
          if (wr_addr == 4'(6 + i)) acc_q[8*i +: 8] <= wr_data;
      end else if (clr_now) acc_q <= '0;
      else if (shf_now)
        acc_q <= cfg_q[4] ? {acc_q[ACCW-1], acc_q[ACCW-1:1]} : {acc_q[ACCW-2:0], 1'b0};
      else if (s1_v) acc_q <= sum;

      if (flg_wr) flg_q <= wr_data[2:0];
      else if (clr_now) flg_q <= '0;
      else if (s1_v) begin
        flg_q[0] <= sum == '0;
        if (sov) flg_q[1] <= 1'b1;
        if (!s1_mode && hov) flg_q[2] <= 1'b1;
      end

      rnd_q <= rnd_nxt;
    end
  end

  assign acc_o   = acc_q;
  assign rnd_o   = rnd_q;
  assign flags_o = flg_q;
  assign cfg_o   = cfg_q;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !acc_wr && !flg_wr) |=> (acc_q == '0 && flg_q == '0));
  assert_shift_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_now && !flg_wr && !clr_now && !s1_v) |=> $stable(flg_q));
  assert_shift_selfclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_now && !cfg_wr) |=> !cfg_q[3]);
  assert_hov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_mode && !flg_wr && !clr_now) |=> $stable(flg_q[2]));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[1] && !flg_wr && !clr_now) |=> flg_q[1]);
  assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1] && !hi_ok) |=> (rnd_q == 16'h7fff || rnd_q == 16'h8000));
endmodule

// File: tb/mac_pipe_test.sv
module mac_pipe_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [39:0] acc_o;
  logic [15:0] rnd_o;
  logic [2:0]  flags_o;
  logic [4:0]  cfg_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [39:0] m_acc = '0;
  logic [2:0]  m_flg = '0;
  logic [4:0]  m_cfg = '0;

  mac_pipe uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .acc_o, .rnd_o, .flags_o, .cfg_o);

  always #5 clk = ~clk;

  function automatic longint sx40(input logic [39:0] x);
    return longint'({{24{x[39]}}, x});
  endfunction

  function automatic logic [15:0] f_round(input logic [39:0] x, input logic sat);
    logic [16:0] r;
    logic ok;
    r  = {x[31], x[31:16]} + {16'd0, x[15]};
    ok = (x[39:31] == '0) || (x[39:31] == '1);
    if (sat && (!ok || r[16] != r[15])) return x[39] ? 16'h8000 : 16'h7fff;
    return r[15:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_op(input logic [15:0] a, input logic [15:0] b);
    longint s, p, base;
    if (m_cfg[2]) begin m_acc = '0; m_flg = '0; m_cfg[2] = 1'b0; end
    p    = longint'($signed(a)) * longint'($signed(b));
    base = m_cfg[0] ? 64'sd0 : sx40(m_acc);
    s    = base + p;
    if (!m_cfg[0] && (s > 64'sh7F_FFFF_FFFF || s < -64'sh80_0000_0000)) m_flg[2] = 1'b1;
    m_acc = s[39:0];
    if (sx40(m_acc) > 64'sh7FFF_FFFF || sx40(m_acc) < -64'sh8000_0000) m_flg[1] = 1'b1;
    m_flg[0] = (m_acc == '0);
  endtask

  task automatic set_cfg(input logic [4:0] c);
    wr(4'd4, {3'b0, c});
    m_cfg = c;
  endtask

  task automatic preload(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(6 + i), v[8*i +: 8]);
    m_acc = v;
  endtask

  task automatic load_ops(input logic [15:0] a, input logic [15:0] b);
    wr(4'd0, a[7:0]); wr(4'd1, a[15:8]); wr(4'd2, b[15:8]);
  endtask

  task automatic launch(input logic [15:0] a, input logic [15:0] b);
    load_ops(a, b);
    wr(4'd3, b[7:0]);
    model_op(a, b);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " acc"}, 64'(acc_o), 64'(m_acc));
    chk({tag, " flags"}, 64'(flags_o), 64'(m_flg));
    chk({tag, " rnd"}, 64'(rnd_o), 64'(f_round(m_acc, m_cfg[1])));
    chk({tag, " cfg"}, 64'(cfg_o), 64'(m_cfg));
  endtask

  task automatic do_shift(input logic dir);
    set_cfg({dir, 1'b1, m_cfg[2:0]});
    m_acc = dir ? {m_acc[39], m_acc[39:1]} : {m_acc[38:0], 1'b0};
    m_cfg[3] = 1'b0;
    idle(2);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] saved;
    logic [39:0] old;
    int unsigned seed;
    seed = $urandom(32'd2718);
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset acc", 64'(acc_o), 0);
    chk("R1 reset flags", 64'(flags_o), 0);
    chk("R1 reset rnd", 64'(rnd_o), 0);
    chk("R1 reset cfg", 64'(cfg_o), 0);

    // R3 timing: accumulate, sample after edges t+1, t+2, t+3
    preload(40'h00_0001_0000);
    idle(2);
    old = m_acc;
    launch(16'h0123, 16'hFF10);
    idle(1);
    chk("R3 acc unchanged after first edge", 64'(acc_o), 64'(old));
    idle(1);
    chk("R3 acc after second edge", 64'(acc_o), 64'(m_acc));
    chk("R5 rnd still old", 64'(rnd_o), 64'(f_round(old, 1'b0)));
    idle(1);
    chk("R5 rnd updated", 64'(rnd_o), 64'(f_round(m_acc, 1'b0)));
    check_all("R3 R7 accumulate");

    // R4 multiply-only overwrite
    set_cfg(5'b00001);
    launch(16'h8000, 16'h8000);
    idle(3);
    check_all("R4 multiply-only");

    // R7 hard overflow, then R4 keeps it
    set_cfg(5'b00000);
    wr(4'd5, 8'h00); m_flg = '0;
    preload(40'h7F_FFFF_FFFF);
    launch(16'h7FFF, 16'h7FFF);
    idle(3);
    chk("R7 hard overflow set", 64'(flags_o[2]), 1);
    check_all("R7 overflow");
    set_cfg(5'b00001);
    launch(16'h0002, 16'h0003);
    idle(3);
    chk("R4 hard overflow kept", 64'(flags_o[2]), 1);
    check_all("R4 keep");

    // R6 saturation and rounding edge
    set_cfg(5'b00010);
    preload(40'h00_7FFF_8000);
    idle(2);
    chk("R6 round overflow clamps", 64'(rnd_o), 64'h7fff);
    preload(40'hF0_0000_0000);
    idle(2);
    chk("R6 negative clamp", 64'(rnd_o), 64'h8000);
    set_cfg(5'b00000);
    idle(2);
    chk("R5 no saturation wraps", 64'(rnd_o), 64'(f_round(40'hF0_0000_0000, 1'b0)));

    // R8 clear on launch
    wr(4'd5, 8'h07); m_flg = 3'b111;
    preload(40'h12_3456_789A);
    set_cfg(5'b00100);
    launch(16'hFFFF, 16'h0005);
    idle(3);
    check_all("R8 clear then add");

    // R9 shifts
    preload(40'h80_0000_0003);
    do_shift(1'b1);
    check_all("R9 right sign fill");
    do_shift(1'b0);
    check_all("R9 left");

    // R10 two launches two clocks apart
    set_cfg(5'b00000);
    preload(40'h00_0000_1000);
    load_ops(16'h0300, 16'h0200);
    wr(4'd3, 8'h11);
    model_op(16'h0300, 16'h0211);
    idle(1);
    wr(4'd3, 8'h22);
    model_op(16'h0300, 16'h0222);
    idle(3);
    check_all("R10 overlap");

    // R11 host write wins over accumulate stage
    preload(40'h01_0203_0405);
    saved = m_acc;
    launch(16'h0010, 16'h0020);
    wr(4'd0, 8'h10);
    wr(4'd6, 8'h5A);
    m_acc = {saved[39:8], 8'h5A};
    idle(2);
    check_all("R11 precedence");
    wr(4'd5, 8'h00); m_flg = '0;
    idle(1);
    chk("R11 flag write", 64'(flags_o), 0);

    // R2 R3 R4 R6 R7 R8 R9 random mix
    for (int it = 0; it < 300; it++) begin
      int k;
      logic [15:0] ra, rb;
      k  = int'($urandom % 10);
      ra = $urandom;
      rb = $urandom;
      if ($urandom % 6 == 0) ra = 16'h8000;
      if ($urandom % 6 == 0) rb = 16'h7FFF;
      case (k)
        0: begin preload({8'($urandom), 32'($urandom)}); idle(2); check_all("R2 preload"); end
        1: begin wr(4'd5, 8'h00); m_flg = '0; idle(1); check_all("R7 flag clear"); end
        2: begin do_shift(1'($urandom)); check_all("R9 random shift"); end
        3: begin set_cfg({2'b00, 1'b1, 2'($urandom)}); launch(ra, rb); idle(3); check_all("R8 random clear"); end
        default: begin set_cfg({3'b000, 2'($urandom)}); launch(ra, rb); idle(3); check_all("R3 R4 R6 random op"); end
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule